// File: doc/BRIEF.md
# Byte-Lane Write Enable Decoder

This block sits on the data path of a four-lane synchronous memory and turns a set of active-low write strobes into per-lane write pulses. On every rising clock edge it samples a global write strobe, a byte-write qualifier, one enable per lane and the processor address strobe. From these it forms a registered one-cycle write pulse for each lane and a registered classification of the cycle as a write or a read.

The same edge loads the input data register lane by lane: only the lanes being written take new data, and the other lanes keep their contents. The block also produces the data-bus drive enable. This signal follows the output-enable pin without waiting for a clock edge, and it is forced off while the cycle is classified as a write.

A parameter selects between the 32-bit variant, which has no parity bit, and the 36-bit variant. In the 36-bit variant each lane carries a parity bit, and a lane write covers that bit as well.

Top module: `lane_wr_decoder`

## Requirements
- R1: When `gwe_ni` is sampled low, all four bits of `lane_wr_o` are 1 after that edge, whatever `bwe_ni`, `lane_en_ni` and `adsp_ni` are.
- R2: When `gwe_ni` is high, `bwe_ni` is low and `adsp_ni` is high at an edge, `lane_wr_o[i]` is 1 after that edge exactly for each lane i whose `lane_en_ni[i]` is low.
- R3: When `gwe_ni` and `bwe_ni` are both sampled high, `lane_wr_o` is 0 and `cyc_write_o` is 0 after that edge.
- R4: When `gwe_ni` is high, `bwe_ni` is low and all of `lane_en_ni` are high at an edge, the cycle is a read: `lane_wr_o` is 0 and `cyc_write_o` is 0.
- R5: On an edge that samples `adsp_ni` low, `lane_en_ni` is ignored, so with `gwe_ni` high no lane is written. Later edges sample the lane enables as normal.
- R6: Every lane write pulse lasts exactly one cycle. If the next edge samples no write for that lane, `lane_wr_o[i]` returns to 0.
- R7: On an edge that writes lane i, `wdata_q_o[i*W +: W]` loads `wdata_i[i*W +: W]`, where W is 9 with parity (bit 8 of the lane is parity) and 8 without. Lanes that are not written hold their value.
- R8: `cyc_write_o` is 1 after an edge exactly when at least one lane was written at that edge.
- R9: `dq_oe_o` is 1 only while `oe_ni` is low and `cyc_write_o` is 0. It responds to `oe_ni` with no clock edge.
- R10: While `rst_ni` is low, `lane_wr_o`, `cyc_write_o` and `wdata_q_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; rising edge samples all strobes |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gwe_ni | input | 1 | Global write strobe, active low |
| bwe_ni | input | 1 | Byte-write qualifier, active low |
| lane_en_ni | input | 4 | Per-lane write enables, active low |
| adsp_ni | input | 1 | Processor address strobe, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | 36 | Write data, lane i at bits [i*9 +: 9] |
| lane_wr_o | output | 4 | Registered per-lane write pulses |
| cyc_write_o | output | 1 | Registered cycle class: 1 write, 0 read |
| dq_oe_o | output | 1 | Data-bus drive enable |
| wdata_q_o | output | 36 | Data input register |

## Verification
A wrong decode shows up on `lane_wr_o` and `cyc_write_o` one edge after the offending strobe pattern. Each cycle either carries a fresh pulse or none, so a corrupted pulse register is visible in the very next cycle.

A wrong capture enable shows up in the data register on the same edge, either as an untouched lane taking new data or as a written lane keeping stale data. Because the bench changes the write data on every vector, such an error never stays hidden for more than one cycle.

A wrong write state shows up on `dq_oe_o` as soon as `oe_ni` changes, with no clock edge needed.

// File: rtl/lane_wr_pkg.sv
package lane_wr_pkg;
  localparam int unsigned BYTE_BITS = 8;

  function automatic int unsigned lane_width(input int unsigned par_bits);
    return BYTE_BITS + par_bits;
  endfunction
endpackage

// File: rtl/lane_wr_decode.sv
module lane_wr_decode #(
  parameter int unsigned LANES = 4
) (
  input  logic             gwe_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] lane_en_ni,
  input  logic             adsp_ni,
  output logic [LANES-1:0] lane_wr_d_o,
  output logic             any_wr_d_o
);
  logic [LANES-1:0] lane_sel;

  // strobe edge masks the lane enables
  always_comb begin
    lane_sel = adsp_ni ? ~lane_en_ni : '0;
    if (!gwe_ni)      lane_wr_d_o = '1;
    else if (!bwe_ni) lane_wr_d_o = lane_sel;
    else              lane_wr_d_o = '0;
  end

  assign any_wr_d_o = |lane_wr_d_o;
endmodule

// File: rtl/lane_wr_slice.sv
module lane_wr_slice
  import lane_wr_pkg::*;
#(
  parameter int unsigned PAR_BITS = 1,
  localparam int unsigned W = lane_width(PAR_BITS)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] d_i,
  output logic         wr_o,
  output logic [W-1:0] q_o
);
  logic                 wr_q;
  logic [BYTE_BITS-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= 1'b0;
      dat_q <= '0;
    end else begin
      wr_q <= wr_en_i;
      if (wr_en_i) dat_q <= d_i[BYTE_BITS-1:0];
    end
  end

  generate
    if (PAR_BITS > 0) begin : g_par
      logic [PAR_BITS-1:0] par_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      par_q <= '0;
        else if (wr_en_i) par_q <= d_i[W-1:BYTE_BITS];
      end
      assign q_o = {par_q, dat_q};

      a_r7_par_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(par_q));
    end else begin : g_nopar
      assign q_o = dat_q;
    end
  endgenerate

  assign wr_o = wr_q;

  a_r7_dat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(dat_q));
  a_r6_pulse_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !wr_o);
endmodule

// File: rtl/lane_wr_decoder.sv
module lane_wr_decoder
  import lane_wr_pkg::*;
#(
  parameter int unsigned LANES    = 4,
  parameter int unsigned PAR_BITS = 1,
  localparam int unsigned W  = lane_width(PAR_BITS),
  localparam int unsigned DW = LANES * W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gwe_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] lane_en_ni,
  input  logic             adsp_ni,
  input  logic             oe_ni,
  input  logic [DW-1:0]    wdata_i,
  output logic [LANES-1:0] lane_wr_o,
  output logic             cyc_write_o,
  output logic             dq_oe_o,
  output logic [DW-1:0]    wdata_q_o
);
  logic [LANES-1:0] lane_wr_d;
  logic             any_wr_d;
  logic             cyc_write_q;

  lane_wr_decode #(.LANES(LANES)) i_decode (
    .gwe_ni      (gwe_ni),
    .bwe_ni      (bwe_ni),
    .lane_en_ni  (lane_en_ni),
    .adsp_ni     (adsp_ni),
    .lane_wr_d_o (lane_wr_d),
    .any_wr_d_o  (any_wr_d)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      lane_wr_slice #(.PAR_BITS(PAR_BITS)) i_slice (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (lane_wr_d[l]),
        .d_i     (wdata_i[l*W +: W]),
        .wr_o    (lane_wr_o[l]),
        .q_o     (wdata_q_o[l*W +: W])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_write_q <= 1'b0;
    else         cyc_write_q <= any_wr_d;
  end

  assign cyc_write_o = cyc_write_q;
  // asynchronous output enable, gated by registered write state
  assign dq_oe_o     = !oe_ni && !cyc_write_q;

  a_r1_global_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gwe_ni |=> (lane_wr_o == '1));
  a_r3_bwe_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gwe_ni && bwe_ni) |=> (lane_wr_o == '0) && !cyc_write_o);
  a_r5_strobe_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gwe_ni && !adsp_ni) |=> (lane_wr_o == '0));
  a_r8_class_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_write_o == (lane_wr_o != '0));
  a_r9_drive_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_write_o |-> !dq_oe_o);
endmodule

// File: tb/test_lane_wr_decoder.sv
module test_lane_wr_decoder;
  localparam int unsigned LANES = 4;
  localparam int unsigned W     = 9;
  localparam int unsigned DW    = LANES * W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             gwe_ni = 1'b1, bwe_ni = 1'b1, adsp_ni = 1'b1, oe_ni = 1'b1;
  logic [LANES-1:0] lane_en_ni = '1;
  logic [DW-1:0]    wdata_i = '0;
  logic [LANES-1:0] lane_wr_o;
  logic             cyc_write_o, dq_oe_o;
  logic [DW-1:0]    wdata_q_o;

  int unsigned n_vec = 0, n_bad = 0;
  logic [DW-1:0] exp_q = '0;

  always #5 clk_i = ~clk_i;

  lane_wr_decoder i_lane_wr_decoder (
    .clk_i, .rst_ni, .gwe_ni, .bwe_ni, .lane_en_ni, .adsp_ni, .oe_ni,
    .wdata_i, .lane_wr_o, .cyc_write_o, .dq_oe_o, .wdata_q_o
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] make_data(input int unsigned v);
    logic [DW-1:0] d;
    for (int l = 0; l < LANES; l++) d[l*W +: W] = 9'((v * 37 + l * 91 + 5) & 9'h1ff);
    return d;
  endfunction

  // apply one strobe pattern and check outputs after the capturing edge
  task automatic step(input logic g, input logic b, input logic [3:0] en,
                      input logic a, input int unsigned seed);
    logic [LANES-1:0] exp_wr;
    logic [DW-1:0]    d;
    @(negedge clk_i);
    d = make_data(seed);
    gwe_ni = g; bwe_ni = b; lane_en_ni = en; adsp_ni = a; wdata_i = d; oe_ni = 1'b1;
    if (!g)                exp_wr = '1;
    else if (!b && a)      exp_wr = ~en;
    else                   exp_wr = '0;
    for (int l = 0; l < LANES; l++) if (exp_wr[l]) exp_q[l*W +: W] = d[l*W +: W];
    @(posedge clk_i); #2;
    if (!g)              chk(lane_wr_o == exp_wr, "R1", 64'(lane_wr_o), 64'(exp_wr));
    else if (!a)         chk(lane_wr_o == exp_wr, "R5", 64'(lane_wr_o), 64'(exp_wr));
    else if (b)          chk(lane_wr_o == exp_wr, "R3", 64'(lane_wr_o), 64'(exp_wr));
    else if (en == 4'hf) chk(lane_wr_o == exp_wr, "R4", 64'(lane_wr_o), 64'(exp_wr));
    else                 chk(lane_wr_o == exp_wr, "R2", 64'(lane_wr_o), 64'(exp_wr));
    chk(cyc_write_o == (exp_wr != '0), "R8", 64'(cyc_write_o), 64'(exp_wr != '0));
    chk(wdata_q_o == exp_q, "R7", 64'(wdata_q_o), 64'(exp_q));
    chk(dq_oe_o == 1'b0, "R9 oe high", 64'(dq_oe_o), 64'd0);
    oe_ni = 1'b0; #1;
    chk(dq_oe_o == (exp_wr == '0), "R9 oe low", 64'(dq_oe_o), 64'(exp_wr == '0));
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    wdata_i = make_data(99); gwe_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #2;
    chk(lane_wr_o == '0, "R10 lanes", 64'(lane_wr_o), 64'd0);
    chk(cyc_write_o == 1'b0, "R10 class", 64'(cyc_write_o), 64'd0);
    chk(wdata_q_o == '0, "R10 data", 64'(wdata_q_o), 64'd0);
    oe_ni = 1'b0; #1;
    chk(dq_oe_o == 1'b1, "R9 reset oe", 64'(dq_oe_o), 64'd1);
    @(negedge clk_i); gwe_ni = 1'b1; rst_ni = 1'b1;

    // exhaustive sweep of strobes, twice with different data
    for (int r = 0; r < 2; r++)
      for (int v = 0; v < 128; v++)
        step(v[0], v[1], v[5:2], v[6], v + r * 128);

    // R6: write then idle, pulse must drop after one cycle
    step(1'b0, 1'b1, 4'hf, 1'b1, 300);
    step(1'b1, 1'b1, 4'h0, 1'b1, 301);
    chk(lane_wr_o == '0, "R6 drop", 64'(lane_wr_o), 64'd0);
    step(1'b1, 1'b0, 4'b1010, 1'b1, 302);
    step(1'b1, 1'b0, 4'b1010, 1'b1, 303);
    chk(lane_wr_o == 4'b0101, "R6 repeat", 64'(lane_wr_o), 64'h5);
    step(1'b1, 1'b0, 4'hf, 1'b1, 304);
    chk(lane_wr_o == '0, "R6 end", 64'(lane_wr_o), 64'd0);
    // R5: strobe edge masks enables, next edge samples them
    step(1'b1, 1'b0, 4'b0000, 1'b0, 305);
    chk(lane_wr_o == '0, "R5 masked", 64'(lane_wr_o), 64'd0);
    step(1'b1, 1'b0, 4'b0000, 1'b1, 306);
    chk(lane_wr_o == '1, "R5 next edge", 64'(lane_wr_o), 64'hf);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule